// File: doc/BRIEF.md
# Four-Entry Pseudo-LRU Replacement Tracker

This block keeps a six-bit use history for a small, fully associative translation table of four entries, and tells the refill logic which entry to evict next. Each entry owns a fixed group of history bits. Using that entry forces its group to one fixed pattern. The replacement choice is made by looking for an entry whose group currently holds the exact complement of that pattern. This means the entry was not touched since its peers last were.

A lookup hit is reported with a strobe and the entry number. A refill request marks the current victim as used in the same cycle as it is taken. The victim number and an illegal-pattern flag are always driven from the stored history. Software can read the history and overwrite it at any time, so it can seed a known state. The history bits are named h5 (most significant) down to h0. Port bit 5 carries h5.

Top module: `plru_tracker`

## Requirements
- R1: After reset the history reads 6'b000000, the victim is entry 3 and the illegal flag is low.
- R2: A use of entry 0 clears h5, h4 and h3 and leaves h2..h0 unchanged, one clock after the request.
- R3: A use of entry 1 sets h5, clears h2 and h1, and leaves h4, h3 and h0 unchanged.
- R4: A use of entry 2 sets h4 and h2, clears h0, and leaves h5, h3 and h1 unchanged.
- R5: A use of entry 3 sets h3, h1 and h0 and leaves h5, h4 and h2 unchanged.
- R6: The victim is chosen from the current history by the first of these conditions that holds, checked in this order. Entry 0 if h5=h4=h3=1. Entry 1 if h5=0 and h2=h1=1. Entry 2 if h4=0, h2=0 and h0=1. Entry 3 if h3=h1=h0=0.
- R7: When none of the R6 conditions holds, the illegal flag is high and the victim output is entry 0. Otherwise the flag is low.
- R8: A refill request updates the history as a use of the victim shown in that cycle.
- R9: A software write loads its 6-bit value into the history on the next clock, overriding any hit or refill in the same cycle. The history read port always shows the stored value.
- R10: When a refill and a hit arrive in the same cycle without a write, the refill's update is applied and the hit is ignored.
- R11: With no write, refill or hit, the history holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_vld | input | 1 | Lookup hit strobe |
| hit_idx | input | 2 | Entry number that hit |
| refill_req | input | 1 | Refill request; marks the victim as used |
| victim_idx | output | 2 | Entry to replace, decoded from the current history |
| pattern_err | output | 1 | History matches no victim condition |
| sw_wr_en | input | 1 | Software write strobe for the history |
| sw_wr_data | input | 6 | Value to load; bit 5 is h5 |
| hist_rd | output | 6 | Current history; bit 5 is h5 |

## Verification
A wrong update mask shows up on the history read port one clock after the hit or refill. Through the decoder, it usually also shows as a wrong victim number in that same cycle. A decoder fault needs no clock at all: the victim and illegal flag follow the stored history combinationally. Seeding the history through the write port lets each decode branch, and each illegal pattern, be observed right after one write. Priority faults between write, refill and hit appear as a one-cycle divergence in the history after a collision.

// File: rtl/plru_pkg.sv
package plru_pkg;

    localparam int unsigned NUM_ENTRIES = 4;
    localparam int unsigned IDX_W       = $clog2(NUM_ENTRIES);
    localparam int unsigned HIST_W      = 6;

    typedef logic [HIST_W-1:0] hist_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        hist_t hist;
    } trk_state_t;

    // Bits owned by each entry: a use forces them to grp_val,
    // the entry becomes victim when they hold ~grp_val.
    function automatic hist_t grp_mask(input int unsigned e);
        case (e)
            0:       grp_mask = 6'b111000;
            1:       grp_mask = 6'b100110;
            2:       grp_mask = 6'b010101;
            default: grp_mask = 6'b001011;
        endcase
    endfunction

    function automatic hist_t grp_val(input int unsigned e);
        case (e)
            0:       grp_val = 6'b000000;
            1:       grp_val = 6'b100000;
            2:       grp_val = 6'b010100;
            default: grp_val = 6'b001011;
        endcase
    endfunction

endpackage

// File: rtl/plru_mark.sv
module plru_mark
    import plru_pkg::*;
(
    input  hist_t hist_in,
    input  idx_t  use_idx,
    output hist_t hist_out
);

    hist_t cand [NUM_ENTRIES];

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cand
        localparam hist_t MASK = grp_mask(e);
        localparam hist_t VAL  = grp_val(e);
        assign cand[e] = (hist_in & ~MASK) | (VAL & MASK);
    end

    always_comb begin
        hist_out = cand[use_idx];
    end

endmodule

// File: rtl/plru_pick.sv
module plru_pick
    import plru_pkg::*;
(
    input  hist_t hist_in,
    output idx_t  victim,
    output logic  no_match
);

    logic [NUM_ENTRIES-1:0] match;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
        localparam hist_t MASK = grp_mask(e);
        localparam hist_t VAL  = grp_val(e);
        assign match[e] = ((hist_in & MASK) == (~VAL & MASK));
    end

    always_comb begin
        victim   = '0;
        no_match = (match == '0);
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) victim = idx_t'(i);
        end
    end

    always_comb begin
        assert_err_forces_zero_R7: assert (!no_match || victim == '0);
    end

endmodule

// File: rtl/plru_tracker.sv
module plru_tracker
    import plru_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_vld,
    input  logic [1:0] hit_idx,
    input  logic       refill_req,
    output logic [1:0] victim_idx,
    output logic       pattern_err,
    input  logic       sw_wr_en,
    input  logic [5:0] sw_wr_data,
    output logic [5:0] hist_rd
);

    trk_state_t st_d, st_q;
    idx_t       pick_idx;
    logic       pick_err;
    idx_t       use_idx;
    hist_t      marked;

    plru_pick u_pick (
        .hist_in  (st_q.hist),
        .victim   (pick_idx),
        .no_match (pick_err)
    );

    plru_mark u_mark (
        .hist_in  (st_q.hist),
        .use_idx  (use_idx),
        .hist_out (marked)
    );

    always_comb begin
        st_d    = st_q;
        use_idx = refill_req ? pick_idx : hit_idx;
        if (sw_wr_en) begin
            st_d.hist = sw_wr_data;
        end else if (refill_req || hit_vld) begin
            st_d.hist = marked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign victim_idx  = pick_idx;
    assign pattern_err = pick_err;
    assign hist_rd     = st_q.hist;

    assert_wr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> hist_rd == $past(sw_wr_data));

    assert_use0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && !refill_req && hit_vld && hit_idx == 2'd0)
        |=> (hist_rd[5:3] == 3'b000 && hist_rd[2:0] == $past(hist_rd[2:0])));

    assert_use3_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && !refill_req && hit_vld && hit_idx == 2'd3)
        |=> (hist_rd[3] && hist_rd[1] && hist_rd[0]));

    assert_refill_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && refill_req && victim_idx == 2'd1)
        |=> (hist_rd[5] && !hist_rd[2] && !hist_rd[1]));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && !refill_req && !hit_vld) |=> $stable(hist_rd));

endmodule

// File: tb/plru_tracker_tb_top.sv
module plru_tracker_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hit_vld = 1'b0;
    logic [1:0] hit_idx = '0;
    logic       refill_req = 1'b0;
    logic       sw_wr_en = 1'b0;
    logic [5:0] sw_wr_data = '0;
    logic [1:0] victim_idx;
    logic       pattern_err;
    logic [5:0] hist_rd;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    plru_tracker dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_vld     (hit_vld),
        .hit_idx     (hit_idx),
        .refill_req  (refill_req),
        .victim_idx  (victim_idx),
        .pattern_err (pattern_err),
        .sw_wr_en    (sw_wr_en),
        .sw_wr_data  (sw_wr_data),
        .hist_rd     (hist_rd)
    );

    // {wr, refill, hit, idx[2], wdata[6], exp_hist[6], exp_victim[2], exp_err}
    localparam int NV = 15;
    localparam logic [19:0] VEC [NV] = '{
        {3'b010, 2'd0, 6'h00, 6'h0B, 2'd2, 1'b0},  // R8 R5 refill victim 3
        {3'b010, 2'd0, 6'h00, 6'h1E, 2'd1, 1'b0},  // R8 R4
        {3'b010, 2'd0, 6'h00, 6'h38, 2'd0, 1'b0},  // R8 R3
        {3'b010, 2'd0, 6'h00, 6'h00, 2'd3, 1'b0},  // R8 R2
        {3'b001, 2'd2, 6'h00, 6'h14, 2'd3, 1'b0},  // R4 hit
        {3'b001, 2'd3, 6'h00, 6'h1F, 2'd1, 1'b0},  // R5 hit
        {3'b001, 2'd0, 6'h00, 6'h07, 2'd1, 1'b0},  // R2 hit
        {3'b001, 2'd1, 6'h00, 6'h21, 2'd2, 1'b0},  // R3 hit, R6 entry 2
        {3'b100, 2'd0, 6'h3F, 6'h3F, 2'd0, 1'b0},  // R9 write, R6 entry 0
        {3'b100, 2'd0, 6'h2A, 6'h2A, 2'd0, 1'b1},  // R7 illegal
        {3'b001, 2'd1, 6'h00, 6'h28, 2'd0, 1'b1},  // R3 from illegal, R7
        {3'b101, 2'd0, 6'h07, 6'h07, 2'd1, 1'b0},  // R9 write beats hit
        {3'b011, 2'd3, 6'h00, 6'h21, 2'd2, 1'b0},  // R10 refill beats hit
        {3'b110, 2'd0, 6'h38, 6'h38, 2'd0, 1'b0},  // R9 write beats refill
        {3'b000, 2'd0, 6'h00, 6'h38, 2'd0, 1'b0}   // R11 idle hold
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic rf, input logic ht,
                        input logic [1:0] idx, input logic [5:0] wd);
        @(negedge clk);
        sw_wr_en = wr; refill_req = rf; hit_vld = ht;
        hit_idx = idx; sw_wr_data = wd;
        @(negedge clk);
        sw_wr_en = 1'b0; refill_req = 1'b0; hit_vld = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 hist", hist_rd, 6'h00);
        check("R1 victim", victim_idx, 2'd3);
        check("R1 err", pattern_err, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            step(v[19], v[18], v[17], v[16:15], v[14:9]);
            check($sformatf("R2-5/R8-11 vec%0d hist", i), hist_rd, v[8:3]);
            check($sformatf("R6 vec%0d victim", i), victim_idx, v[2:1]);
            check($sformatf("R7 vec%0d err", i), pattern_err, v[0]);
        end

        // R6: each decode branch seeded by write
        step(1'b1, 1'b0, 1'b0, 2'd0, 6'h06);   // h2=h1=1, h5=0 -> entry 1
        check("R6 seed 0x06 victim", victim_idx, 2'd1);
        step(1'b1, 1'b0, 1'b0, 2'd0, 6'h3E);   // h5h4h3=111 wins over others
        check("R6 order 0x3E victim", victim_idx, 2'd0);
        step(1'b1, 1'b0, 1'b0, 2'd0, 6'h15);   // no condition
        check("R7 seed 0x15 err", pattern_err, 1);
        check("R7 seed 0x15 victim", victim_idx, 2'd0);

        // R10 with hit on an untouched group: refill of victim 3 from 0x00
        step(1'b1, 1'b0, 1'b0, 2'd0, 6'h00);
        step(1'b0, 1'b1, 1'b1, 2'd2, 6'h00);
        check("R10 refill over hit hist", hist_rd, 6'h0B);

        // R1 again: reset mid-run
        step(1'b1, 1'b0, 1'b0, 2'd0, 6'h2A);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset hist", hist_rd, 6'h00);
        check("R1 re-reset victim", victim_idx, 2'd3);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule